// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block sits between a bus slave port that serves an alias window of 32 MB and a bus master port that reaches a 1 MB target memory region. Every 32-bit word in the alias window stands for one bit of the target region. An access to an alias word turns into an access to the byte, halfword or word in the target that holds that bit. The block then either extracts the bit or changes only that bit.

A read fetches the target unit at the requested size and returns 0 or 1. A write fetches the unit, sets or clears the one selected bit according to bit 0 of the write data, and stores the unit back at the same size. Both beats of a write carry a lock indication, so no other master can touch the unit in between. The base address of the target region is a parameter. A second parameter byte-swaps the bit mask for memories whose byte order differs from the bus.

Only one alias access is in flight at a time. The slave port drops ready from acceptance until the response pulse. An error on either master beat ends the access early and is reported on the slave side.

Top module: `bitband_bridge`

## Requirements
- R1: The target address is TARGET_BASE ORed with the alias offset shifted right by 5. Bit 0 of it is cleared for halfword accesses, and bits 1:0 are cleared for word accesses. Size encoding: 0 = byte, 1 = halfword, 2 = word.
- R2: The selected bit within the unit is offset[4:2] for a byte access, offset[5:2] for a halfword access and offset[6:2] for a word access. Master data is right-justified, with the lowest target byte in bits 7:0.
- R3: A read makes exactly one unlocked master read at the request size. It answers with s_rdata = 1 when the selected bit is set and 0 when it is clear. Bits 31:1 are always zero.
- R4: A write stores back the fetched unit with only the selected bit changed, to the value of s_wdata[0]. Bits 31:1 of s_wdata have no effect.
- R5: A write produces a read beat followed by a write beat to the same address and size. m_lock is high on both beats. The request lines stay stable while m_valid waits for m_ready.
- R6: s_ready is low from the cycle after acceptance until the response pulse has been given. No master request and no response is active while s_ready is high.
- R7: An error on a master beat ends the access with s_err high on the response pulse. An error on the read beat of a write suppresses the write beat and leaves the memory unchanged.
- R8: After synchronous reset the block is idle: s_ready is 1, and m_valid and s_rsp_valid are 0.
- R9: With SWAP_BYTES = 1 the mask is byte-reversed within the unit, so bit k of a unit of N bytes lives in byte N-1-k/8 at bit k%8. Byte accesses are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Alias request valid |
| s_ready | output | 1 | Bridge idle, request accepted when s_valid is high |
| s_write | input | 1 | 1 = alias write, 0 = alias read |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| s_offset | input | ALIAS_AW | Byte offset inside the alias window |
| s_wdata | input | 32 | Write data, only bit 0 used |
| s_rsp_valid | output | 1 | One-cycle response pulse |
| s_rdata | output | 32 | Read result, 0 or 1 |
| s_err | output | 1 | Error flag valid with s_rsp_valid |
| m_valid | output | 1 | Master request valid |
| m_ready | input | 1 | Master request accepted |
| m_write | output | 1 | Master beat is a write |
| m_lock | output | 1 | Beat belongs to a locked read-modify-write |
| m_size | output | 2 | Master access size, same encoding as s_size |
| m_addr | output | 32 | Target byte address |
| m_wdata | output | 32 | Right-justified write-back unit |
| m_rsp_valid | input | 1 | Master response valid |
| m_rdata | input | 32 | Right-justified read unit |
| m_err | input | 1 | Master response error |

## Verification
The bench builds two instances with the default window width and target base 0x2000_0000. The first uses SWAP_BYTES = 0 and the second SWAP_BYTES = 1. Each instance talks to its own 256-byte memory model. Keeping offsets below 8192 holds every target address inside those 256 bytes. Within that range every word-aligned offset is read at all three sizes, so every bit index and both mask orders are covered. A stride of write offsets with both values of bit 0, together with injected errors on the read beat, reaches the bit-preserving write-back and the abort path.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int BUS_W      = 32;
  localparam int BITS_PER_W = 32;   // alias bytes per target byte: 4 bytes x 8 bits
  localparam int ALIAS_SHR  = $clog2(BITS_PER_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bb_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } bb_state_e;

  // Target byte address, aligned down to the access unit.
  function automatic logic [BUS_W-1:0] bb_target_addr(
    input logic [BUS_W-1:0] base,
    input logic [BUS_W-1:0] off,
    input logic [BUS_W-1:0] win_mask,
    input logic [1:0]       sz
  );
    logic [BUS_W-1:0] t;
    t = base | ((off & win_mask) >> ALIAS_SHR);
    case (sz)
      SZ_BYTE: t = t;
      SZ_HALF: t[0] = 1'b0;
      default: t[1:0] = 2'b00;
    endcase
    return t;
  endfunction

  // Bit position within the unit.
  function automatic logic [4:0] bb_bit_index(
    input logic [BUS_W-1:0] off,
    input logic [1:0]       sz
  );
    case (sz)
      SZ_BYTE: return {2'b00, off[4:2]};
      SZ_HALF: return {1'b0, off[5:2]};
      default: return off[6:2];
    endcase
  endfunction

  // All-ones over the bytes a unit occupies.
  function automatic logic [BUS_W-1:0] bb_unit_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // One-hot mask, optionally byte-reversed inside the unit.
  function automatic logic [BUS_W-1:0] bb_bit_mask(
    input logic [4:0] idx,
    input logic [1:0] sz,
    input logic       swap
  );
    logic [BUS_W-1:0] m;
    m = 32'd1 << idx;
    if (swap) begin
      case (sz)
        SZ_BYTE: m = m;
        SZ_HALF: m = {16'h0000, m[7:0], m[15:8]};
        default: m = {m[7:0], m[15:8], m[23:16], m[31:24]};
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/bb_addr_gen.sv
module bb_addr_gen
  import bb_pkg::*;
#(
  parameter int          ALIAS_AW    = 25,
  parameter logic [31:0] TARGET_BASE = 32'h2000_0000,
  parameter bit          SWAP_BYTES  = 1'b0
) (
  input  logic [ALIAS_AW-1:0] offset,
  input  logic [1:0]          size,
  output logic [BUS_W-1:0]    tgt_addr,
  output logic [BUS_W-1:0]    bit_mask,
  output logic [BUS_W-1:0]    unit_mask
);
  localparam logic [BUS_W-1:0] WIN_MASK = BUS_W'((64'd1 << ALIAS_AW) - 64'd1);

  logic [BUS_W-1:0] off_ext;
  logic [4:0]       idx;

  assign off_ext   = BUS_W'(offset);
  assign idx       = bb_bit_index(off_ext, size);
  assign tgt_addr  = bb_target_addr(TARGET_BASE, off_ext, WIN_MASK, size);
  assign bit_mask  = bb_bit_mask(idx, size, SWAP_BYTES);
  assign unit_mask = bb_unit_mask(size);
endmodule

// File: rtl/bb_bit_alu.sv
module bb_bit_alu
  import bb_pkg::*;
(
  input  logic [BUS_W-1:0] unit_in,
  input  logic [BUS_W-1:0] bit_mask,
  input  logic [BUS_W-1:0] unit_mask,
  input  logic             new_bit,
  output logic             bit_out,
  output logic [BUS_W-1:0] unit_out
);
  logic [BUS_W-1:0] merged;

  assign bit_out  = |(unit_in & bit_mask);
  assign merged   = new_bit ? (unit_in | bit_mask) : (unit_in & ~bit_mask);
  assign unit_out = merged & unit_mask;
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      s_valid,
  input  logic      is_write,
  input  logic      m_ready,
  input  logic      m_rsp_valid,
  input  logic      m_err,
  output logic      s_ready,
  output logic      m_valid,
  output logic      m_write,
  output logic      m_lock,
  output logic      s_rsp_valid,
  output logic      accept_evt,
  output logic      rd_done_evt,
  output logic      wr_done_evt,
  output bb_state_e state
);
  bb_state_e nxt;

  assign accept_evt  = (state == ST_IDLE) && s_valid;
  assign rd_done_evt = (state == ST_RD_WAIT) && m_rsp_valid;
  assign wr_done_evt = (state == ST_WR_WAIT) && m_rsp_valid;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (s_valid) nxt = ST_RD_REQ;
      ST_RD_REQ:  if (m_ready) nxt = ST_RD_WAIT;
      ST_RD_WAIT: if (m_rsp_valid) nxt = (m_err || !is_write) ? ST_RESP : ST_WR_REQ;
      ST_WR_REQ:  if (m_ready) nxt = ST_WR_WAIT;
      ST_WR_WAIT: if (m_rsp_valid) nxt = ST_RESP;
      ST_RESP:    nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign s_ready     = (state == ST_IDLE);
  assign m_valid     = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign m_write     = (state == ST_WR_REQ);
  assign m_lock      = is_write && (state inside {ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT});
  assign s_rsp_valid = (state == ST_RESP);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int          ALIAS_AW    = 25,
  parameter logic [31:0] TARGET_BASE = 32'h2000_0000,
  parameter bit          SWAP_BYTES  = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic                s_write,
  input  logic [1:0]          s_size,
  input  logic [ALIAS_AW-1:0] s_offset,
  input  logic [31:0]         s_wdata,
  output logic                s_rsp_valid,
  output logic [31:0]         s_rdata,
  output logic                s_err,
  output logic                m_valid,
  input  logic                m_ready,
  output logic                m_write,
  output logic                m_lock,
  output logic [1:0]          m_size,
  output logic [31:0]         m_addr,
  output logic [31:0]         m_wdata,
  input  logic                m_rsp_valid,
  input  logic [31:0]         m_rdata,
  input  logic                m_err
);
  logic                req_wr_q;
  logic [1:0]          req_size_q;
  logic [ALIAS_AW-1:0] req_off_q;
  logic                req_bit_q;
  logic [BUS_W-1:0]    unit_q;
  logic                err_q;

  // named internal events
  logic      accept_evt, rd_done_evt, wr_done_evt;
  bb_state_e state;

  logic [BUS_W-1:0] tgt_addr, bit_mask, unit_mask, wb_unit;
  logic             sel_bit;

  bb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .s_valid(s_valid), .is_write(req_wr_q),
    .m_ready(m_ready), .m_rsp_valid(m_rsp_valid), .m_err(m_err),
    .s_ready(s_ready), .m_valid(m_valid), .m_write(m_write), .m_lock(m_lock),
    .s_rsp_valid(s_rsp_valid), .accept_evt(accept_evt),
    .rd_done_evt(rd_done_evt), .wr_done_evt(wr_done_evt), .state(state)
  );

  bb_addr_gen #(.ALIAS_AW(ALIAS_AW), .TARGET_BASE(TARGET_BASE), .SWAP_BYTES(SWAP_BYTES)) u_addr (
    .offset(req_off_q), .size(req_size_q),
    .tgt_addr(tgt_addr), .bit_mask(bit_mask), .unit_mask(unit_mask)
  );

  bb_bit_alu u_alu (
    .unit_in(unit_q), .bit_mask(bit_mask), .unit_mask(unit_mask),
    .new_bit(req_bit_q), .bit_out(sel_bit), .unit_out(wb_unit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_wr_q   <= 1'b0;
      req_size_q <= SZ_BYTE;
      req_off_q  <= '0;
      req_bit_q  <= 1'b0;
      unit_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      if (accept_evt) begin
        req_wr_q   <= s_write;
        req_size_q <= s_size;
        req_off_q  <= s_offset;
        req_bit_q  <= s_wdata[0];
        err_q      <= 1'b0;
      end
      if (rd_done_evt) unit_q <= m_rdata & unit_mask;
      if ((rd_done_evt || wr_done_evt) && m_err) err_q <= 1'b1;
    end
  end

  assign m_addr  = tgt_addr;
  assign m_size  = req_size_q;
  assign m_wdata = m_write ? wb_unit : '0;
  assign s_err   = s_rsp_valid && err_q;
  assign s_rdata = (s_rsp_valid && !req_wr_q && !err_q) ? {31'b0, sel_bit} : '0;
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic        s_valid,
  input logic        s_ready,
  input logic        s_rsp_valid,
  input logic [31:0] s_rdata,
  input logic        m_valid,
  input logic        m_ready,
  input logic        m_write,
  input logic        m_lock,
  input logic [1:0]  m_size,
  input logic [31:0] m_addr,
  input logic [31:0] m_wdata,
  input logic        m_rsp_valid,
  input logic [31:0] m_rdata,
  input logic        m_err
);
  logic        was_rst;
  logic        beat_wr;
  logic        err_seen;
  logic [31:0] last_rd;
  logic [31:0] rd_addr;
  logic [1:0]  rd_size;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst) begin
      beat_wr  <= 1'b0;
      err_seen <= 1'b0;
      last_rd  <= '0;
      rd_addr  <= '0;
      rd_size  <= '0;
    end else begin
      if (s_valid && s_ready) err_seen <= 1'b0;
      if (m_valid && m_ready) begin
        beat_wr <= m_write;
        if (!m_write) begin
          rd_addr <= m_addr;
          rd_size <= m_size;
        end
      end
      if (m_rsp_valid) begin
        if (m_err) err_seen <= 1'b1;
        if (!beat_wr) last_rd <= m_rdata;
      end
    end
  end

  // R8: idle right after reset
  a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
    was_rst |-> (s_ready && !m_valid && !s_rsp_valid));

  // R6: no master activity or response while the slave port is ready
  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (m_valid || s_rsp_valid) |-> !s_ready);

  // R5: request held steady under backpressure
  a_r5_hold_request: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_size)));

  // R5: write-back locked and aimed at the unit just read
  a_r5_locked_writeback: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_write) |-> (m_lock && m_addr == rd_addr && m_size == rd_size));

  // R4: write-back differs from fetched unit in at most one bit
  a_r4_single_bit_change: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_write) |-> ($countones(m_wdata ^ last_rd) <= 1));

  // R7: no write-back after an error
  a_r7_no_wb_after_err: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_write) |-> !err_seen);

  // R3: result is a single bit
  a_r3_rdata_one_bit: assert property (@(posedge clk) disable iff (rst)
    s_rsp_valid |-> (s_rdata[31:1] == 31'd0));
endmodule

bind bitband_bridge bitband_bridge_chk u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .s_rsp_valid(s_rsp_valid), .s_rdata(s_rdata), .m_valid(m_valid),
  .m_ready(m_ready), .m_write(m_write), .m_lock(m_lock), .m_size(m_size),
  .m_addr(m_addr), .m_wdata(m_wdata), .m_rsp_valid(m_rsp_valid),
  .m_rdata(m_rdata), .m_err(m_err)
);

// File: tb/bitband_bridge_tb_top.sv
module bb_mem_model #(
  parameter logic [7:0] SEED = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        err_en,
  input  logic        m_valid,
  output logic        m_ready,
  input  logic        m_write,
  input  logic        m_lock,
  input  logic [1:0]  m_size,
  input  logic [31:0] m_addr,
  input  logic [31:0] m_wdata,
  output logic        m_rsp_valid,
  output logic [31:0] m_rdata,
  output logic        m_err
);
  logic [7:0]  mem [256];
  int          rd_cnt, wr_cnt;
  logic [31:0] last_rd_addr;
  logic [1:0]  last_rd_size;
  logic        last_rd_lock, last_wr_lock;

  assign m_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37) ^ SEED;
      m_rsp_valid <= 1'b0;
      m_rdata <= '0;
      m_err <= 1'b0;
      rd_cnt <= 0;
      wr_cnt <= 0;
      last_rd_addr <= '0;
      last_rd_size <= '0;
      last_rd_lock <= 1'b0;
      last_wr_lock <= 1'b0;
    end else begin
      m_rsp_valid <= m_valid;
      m_err <= m_valid && err_en;
      m_rdata <= '0;
      if (m_valid && !m_write) begin
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= m_addr;
        last_rd_size <= m_size;
        last_rd_lock <= m_lock;
        case (m_size)
          2'd0: m_rdata <= {24'h0, mem[m_addr[7:0]]};
          2'd1: m_rdata <= {16'h0, mem[m_addr[7:0] + 8'd1], mem[m_addr[7:0]]};
          default: m_rdata <= {mem[m_addr[7:0] + 8'd3], mem[m_addr[7:0] + 8'd2],
                               mem[m_addr[7:0] + 8'd1], mem[m_addr[7:0]]};
        endcase
      end
      if (m_valid && m_write) begin
        wr_cnt <= wr_cnt + 1;
        last_wr_lock <= m_lock;
        if (!err_en) begin
          mem[m_addr[7:0]] <= m_wdata[7:0];
          if (m_size != 2'd0) mem[m_addr[7:0] + 8'd1] <= m_wdata[15:8];
          if (m_size == 2'd2) begin
            mem[m_addr[7:0] + 8'd2] <= m_wdata[23:16];
            mem[m_addr[7:0] + 8'd3] <= m_wdata[31:24];
          end
        end
      end
    end
  end
endmodule

module bitband_bridge_tb_top;
  localparam int          AW   = 25;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic          s_valid = 1'b0, s_write = 1'b0;
  logic [1:0]    s_size = 2'd0;
  logic [AW-1:0] s_offset = '0;
  logic [31:0]   s_wdata = '0;
  logic          err_en = 1'b0;

  logic        s_ready [2];
  logic        s_rsp_valid [2];
  logic [31:0] s_rdata [2];
  logic        s_err [2];
  logic        m_valid [2], m_ready [2], m_write [2], m_lock [2];
  logic [1:0]  m_size [2];
  logic [31:0] m_addr [2], m_wdata [2], m_rdata [2];
  logic        m_rsp_valid [2], m_err [2];

  bitband_bridge #(.ALIAS_AW(AW), .TARGET_BASE(BASE), .SWAP_BYTES(1'b0)) dut_i (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready[0]), .s_write(s_write),
    .s_size(s_size), .s_offset(s_offset), .s_wdata(s_wdata),
    .s_rsp_valid(s_rsp_valid[0]), .s_rdata(s_rdata[0]), .s_err(s_err[0]),
    .m_valid(m_valid[0]), .m_ready(m_ready[0]), .m_write(m_write[0]), .m_lock(m_lock[0]),
    .m_size(m_size[0]), .m_addr(m_addr[0]), .m_wdata(m_wdata[0]),
    .m_rsp_valid(m_rsp_valid[0]), .m_rdata(m_rdata[0]), .m_err(m_err[0]));

  bitband_bridge #(.ALIAS_AW(AW), .TARGET_BASE(BASE), .SWAP_BYTES(1'b1)) dut_sw_i (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready[1]), .s_write(s_write),
    .s_size(s_size), .s_offset(s_offset), .s_wdata(s_wdata),
    .s_rsp_valid(s_rsp_valid[1]), .s_rdata(s_rdata[1]), .s_err(s_err[1]),
    .m_valid(m_valid[1]), .m_ready(m_ready[1]), .m_write(m_write[1]), .m_lock(m_lock[1]),
    .m_size(m_size[1]), .m_addr(m_addr[1]), .m_wdata(m_wdata[1]),
    .m_rsp_valid(m_rsp_valid[1]), .m_rdata(m_rdata[1]), .m_err(m_err[1]));

  bb_mem_model #(.SEED(8'h00)) mem0 (
    .clk(clk), .rst(rst), .err_en(err_en), .m_valid(m_valid[0]), .m_ready(m_ready[0]),
    .m_write(m_write[0]), .m_lock(m_lock[0]), .m_size(m_size[0]), .m_addr(m_addr[0]),
    .m_wdata(m_wdata[0]), .m_rsp_valid(m_rsp_valid[0]), .m_rdata(m_rdata[0]), .m_err(m_err[0]));

  bb_mem_model #(.SEED(8'h5A)) mem1 (
    .clk(clk), .rst(rst), .err_en(err_en), .m_valid(m_valid[1]), .m_ready(m_ready[1]),
    .m_write(m_write[1]), .m_lock(m_lock[1]), .m_size(m_size[1]), .m_addr(m_addr[1]),
    .m_wdata(m_wdata[1]), .m_rsp_valid(m_rsp_valid[1]), .m_rdata(m_rdata[1]), .m_err(m_err[1]));

  int n_chk = 0, n_bad = 0;
  logic        got_rsp [2];
  logic [31:0] got_data [2];
  logic        got_err [2];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input int inst, input int a);
    return (inst == 0) ? mem0.mem[a] : mem1.mem[a];
  endfunction

  // Expected placement computed from offset arithmetic.
  function automatic int unit_bytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic int exp_addr_low(input int off, input int sz);
    int a;
    a = off / 32;
    return a - (a % unit_bytes(sz));
  endfunction

  function automatic int exp_byte(input int inst, input int off, input int sz);
    int k;
    k = (off / 4) % (8 * unit_bytes(sz));
    return exp_addr_low(off, sz) + ((inst == 1) ? (unit_bytes(sz) - 1 - k / 8) : (k / 8));
  endfunction

  function automatic int exp_bitpos(input int off, input int sz);
    return ((off / 4) % (8 * unit_bytes(sz))) % 8;
  endfunction

  task automatic access(input bit wr, input int sz, input int off, input logic [31:0] wd);
    @(negedge clk);
    s_valid = 1'b1; s_write = wr; s_size = 2'(sz); s_offset = AW'(off); s_wdata = wd;
    for (int i = 0; i < 2; i++) got_rsp[i] = 1'b0;
    @(negedge clk);
    s_valid = 1'b0;
    check(!s_ready[0] && !s_ready[1], "R6 busy after accept", {s_ready[1], s_ready[0]}, 32'h0);
    for (int c = 0; c < 40 && !(got_rsp[0] && got_rsp[1]); c++) begin
      for (int i = 0; i < 2; i++)
        if (s_rsp_valid[i] && !got_rsp[i]) begin
          got_rsp[i] = 1'b1; got_data[i] = s_rdata[i]; got_err[i] = s_err[i];
        end
      if (!(got_rsp[0] && got_rsp[1])) @(negedge clk);
    end
    check(got_rsp[0] && got_rsp[1], "R6 response arrives", {got_rsp[1], got_rsp[0]}, 32'h3);
    @(negedge clk);
    check(s_ready[0] && s_ready[1], "R6 ready after response", {s_ready[1], s_ready[0]}, 32'h3);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] pre [2][4];
    int         a0, rc, wc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R8 reset state
    for (int i = 0; i < 2; i++)
      check(s_ready[i] && !m_valid[i] && !s_rsp_valid[i], "R8 reset idle",
            {s_ready[i], m_valid[i], s_rsp_valid[i]}, 32'h4);

    // R1 R2 R3 R9: read sweep over all aligned offsets and sizes
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 8192; off += 4) begin
        rc = mem0.rd_cnt;
        access(1'b0, sz, off, 32'h0);
        for (int i = 0; i < 2; i++) begin
          logic expb;
          expb = mem_byte(i, exp_byte(i, off, sz))[exp_bitpos(off, sz)];
          check(got_data[i] == {31'b0, expb} && !got_err[i],
                (i == 0) ? "R3 R2 read bit" : "R9 swapped read bit", got_data[i], {31'b0, expb});
        end
        check(mem0.last_rd_addr == BASE + 32'(exp_addr_low(off, sz)), "R1 target address",
              mem0.last_rd_addr, BASE + 32'(exp_addr_low(off, sz)));
        check(mem0.rd_cnt == rc + 1 && mem0.last_rd_size == 2'(sz) && !mem0.last_rd_lock,
              "R3 single unlocked read", mem0.rd_cnt - rc, 32'd1);
      end

    // R4 R5 R9: write sweep
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 8192; off += 36) begin
        logic [31:0] wd;
        wd = ((off / 36) % 2 == 0) ? 32'hFFFF_FFFE : 32'h0000_0001;
        if ((off / 36) % 5 == 0) wd = 32'h0000_0000;
        a0 = exp_addr_low(off, sz);
        for (int i = 0; i < 2; i++)
          for (int b = 0; b < 4; b++) pre[i][b] = mem_byte(i, (a0 + b) % 256);
        wc = mem0.wr_cnt;
        access(1'b1, sz, off, wd);
        for (int i = 0; i < 2; i++) begin
          for (int b = 0; b < 4; b++) begin
            logic [7:0] e;
            e = pre[i][b];
            if (a0 + b == exp_byte(i, off, sz)) e[exp_bitpos(off, sz)] = wd[0];
            check(mem_byte(i, (a0 + b) % 256) == e,
                  (i == 0) ? "R4 write-back byte" : "R9 swapped write-back byte",
                  32'(mem_byte(i, (a0 + b) % 256)), 32'(e));
          end
          check(!got_err[i] && got_data[i] == 32'h0, "R4 write response", got_data[i], 32'h0);
        end
        check(mem0.wr_cnt == wc + 1 && mem0.last_rd_lock && mem0.last_wr_lock,
              "R5 locked read and write beats", {mem0.last_rd_lock, mem0.last_wr_lock}, 32'h3);
      end

    // R7: error on read beat of a write and of a read
    for (int sz = 0; sz < 3; sz++) begin
      a0 = exp_addr_low(1024, sz);
      for (int b = 0; b < 4; b++) pre[0][b] = mem0.mem[a0 + b];
      wc = mem0.wr_cnt;
      err_en = 1'b1;
      access(1'b1, sz, 1024 + 4 * sz, 32'h1);
      err_en = 1'b0;
      check(got_err[0] && got_err[1], "R7 error reported on write", {got_err[1], got_err[0]}, 32'h3);
      check(mem0.wr_cnt == wc, "R7 write-back suppressed", mem0.wr_cnt - wc, 32'h0);
      for (int b = 0; b < 4; b++)
        check(mem0.mem[a0 + b] == pre[0][b], "R7 memory unchanged", 32'(mem0.mem[a0 + b]), 32'(pre[0][b]));
      err_en = 1'b1;
      access(1'b0, sz, 2048, 32'h0);
      err_en = 1'b0;
      check(got_err[0] && got_data[0] == 32'h0, "R7 error reported on read", got_data[0], 32'h0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule